// File: doc/BRIEF.md
# Link Test Pattern Checker

This block sits on the receive side of a serial data link, after the deserializer. It checks the integrity of the link during a test run. The transmitter first sends a short synchronisation run and then a test pattern in one of four modes. The checker holds its own copy of the transmitter's pattern generator, configured to the same mode. It waits for the synchronisation run, aligns its generator to it, and then compares every received 16-bit word against the word it expects.

Two counters are exposed to slow control: one for compared words and one for errors. The block also exposes a locked indication, a sticky error flag, and a sticky flag that reports when the link identifier in static mode is not the one slow control expects. A pulse on `start` clears all results and makes the checker hunt for synchronisation again. The usual sequence is: configure the mode and the expected identifier, pulse `start`, let the transmitter run, then read the counters.

Top module: `link_pattern_checker`

## Requirements
- R1: Reset, or a cycle with `start` high, clears both counters, `locked`, `err_flag` and `id_mismatch`, and restarts the synchronisation hunt. `start` overrides any word received in the same cycle.
- R2: `locked` goes high one cycle after the last of SYNC_LEN (default 2) consecutive valid words equal to SYNC_WORD (default 16'hBC50). A valid word with any other value restarts the run. Cycles with `rx_valid` low do not break the run. Once high, `locked` stays high until `start` or reset.
- R3: While `locked` is low, neither counter changes and no flag is set.
- R4: While locked, `word_count` increases by one for each cycle with `rx_valid` high. Cycles with `rx_valid` low neither count nor advance the local generator.
- R5: While locked, each valid word that differs from the expected word increases `err_count` by one. A valid word received with `rx_err` high also counts as one error. `err_flag` goes high with the first counted error and stays high.
- R6: In ramp mode (`mode`=2), the first word after synchronisation is 0. Each later valid word is one more than the previous one, modulo 2^16.
- R7: In pseudo-random mode (`mode`=3), the first expected word is SEED (default 16'hACE1). Each next word is {s[14:0], s[15]^s[13]^s[12]^s[10]}. The generator is reloaded at every lock and advances once per valid word, so one corrupted word gives exactly one error.
- R8: In static mode (`mode`=0), the expected word is {exp_id, STATIC_LO} with STATIC_LO default 8'h3C. `id_mismatch` is set, and stays set, when a valid word without `rx_err` has an upper byte different from `exp_id`.
- R9: In circular mode (`mode`=1), every valid word must equal CIRC_WORD (default 16'h55AA). After lock, `rx_valid` must change level every cycle. Each cycle that repeats the previous level adds one error. A mismatched data word in a cycle that toggles correctly also adds one error.
- R10: Both counters are CNT_W bits wide (default 32) and saturate at their all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clear results and rehunt for synchronisation |
| mode | input | 2 | Test mode: 0 static, 1 circular, 2 ramp, 3 pseudo-random |
| exp_id | input | 8 | Expected link identifier |
| rx_data | input | 16 | Received word |
| rx_valid | input | 1 | Received word is a data word |
| rx_err | input | 1 | Receiver flagged a coding error on this word |
| locked | output | 1 | Synchronisation found, comparison active |
| err_flag | output | 1 | Sticky: at least one error counted |
| id_mismatch | output | 1 | Sticky: static-mode identifier differs from exp_id |
| err_count | output | CNT_W | Saturating error counter |
| word_count | output | CNT_W | Saturating compared-word counter |

## Verification
If the local generator is misaligned by even one step, `err_count` rises on every valid word from the first word after lock. A single injected fault that shows up as more than one error therefore points to a generator that advanced wrongly or was reloaded wrongly. A broken sync hunt shows as `locked` rising one cycle early, one cycle late, or never, and the cycle right after the final sync word reveals it. Counter faults show as `word_count` disagreeing with the number of valid cycles sent, whether idle cycles are present or not, and as wrap-around after a saturating run.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

  typedef enum logic [1:0] {
    MODE_STATIC = 2'd0,
    MODE_CIRC   = 2'd1,
    MODE_RAMP   = 2'd2,
    MODE_PRBS   = 2'd3
  } lpc_mode_e;

  localparam int unsigned WORD_W = 16;

  // Fibonacci step for x^16 + x^14 + x^13 + x^11 + 1
  function automatic logic [WORD_W-1:0] lfsr_step(input logic [WORD_W-1:0] s);
    return {s[WORD_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/lpc_sync_hunt.sv
module lpc_sync_hunt #(
  parameter int unsigned          WORD_W    = 16,
  parameter int unsigned          SYNC_LEN  = 2,
  parameter logic [WORD_W-1:0]    SYNC_WORD = 16'hBC50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              lock_evt,
  output logic              locked
);

  localparam int unsigned    CW   = (SYNC_LEN > 1) ? $clog2(SYNC_LEN) : 1;
  localparam logic [CW-1:0]  LAST = CW'(SYNC_LEN - 1);

  logic [CW-1:0] run_q;
  logic          is_sync;

  assign is_sync  = rx_valid && (rx_data == SYNC_WORD);
  assign lock_evt = !locked && !start && is_sync && (run_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || start) begin
      run_q  <= '0;
      locked <= 1'b0;
    end else if (!locked) begin
      if (lock_evt) begin
        locked <= 1'b1;
        run_q  <= '0;
      end else if (is_sync) begin
        run_q <= run_q + 1'b1;
      end else if (rx_valid) begin
        run_q <= '0;
      end
    end
  end

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (locked && !start) |=> locked) else $error("lock dropped");  // R2

  AST_LOCK_NEEDS_SYNC: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(is_sync)) else $error("lock without sync");  // R2

endmodule

// File: rtl/lpc_ref_gen.sv
module lpc_ref_gen
  import lpc_pkg::*;
#(
  parameter logic [15:0] SEED      = 16'hACE1,
  parameter logic [7:0]  STATIC_LO = 8'h3C,
  parameter logic [15:0] CIRC_WORD = 16'h55AA
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic        adv,
  input  lpc_mode_e   mode,
  input  logic [7:0]  exp_id,
  output logic [15:0] expected
);

  logic [15:0] ramp_q;
  logic [15:0] lfsr_q;

  always_ff @(posedge clk) begin
    if (rst || load) begin
      ramp_q <= '0;
      lfsr_q <= SEED;
    end else if (adv) begin
      ramp_q <= ramp_q + 16'd1;
      lfsr_q <= lfsr_step(lfsr_q);
    end
  end

  always_comb begin
    unique case (mode)
      MODE_STATIC: expected = {exp_id, STATIC_LO};
      MODE_CIRC:   expected = CIRC_WORD;
      MODE_RAMP:   expected = ramp_q;
      default:     expected = lfsr_q;
    endcase
  end

  AST_LFSR_ALIVE: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != 16'd0) else $error("lfsr stuck at zero");  // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!adv && !load) |=> ($stable(ramp_q) && $stable(lfsr_q))) else $error("generator moved while idle");  // R4

endmodule

// File: rtl/lpc_sat_counter.sv
module lpc_sat_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (inc && (count != TOP)) begin
      count <= count + 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (count == TOP && !clr) |=> count == TOP) else $error("counter wrapped");  // R10

  AST_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
    !clr |=> count >= $past(count)) else $error("counter decreased");  // R10

endmodule

// File: rtl/link_pattern_checker.sv
module link_pattern_checker
  import lpc_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned SYNC_LEN  = 2,
  parameter logic [15:0] SYNC_WORD = 16'hBC50,
  parameter logic [15:0] SEED      = 16'hACE1,
  parameter logic [7:0]  STATIC_LO = 8'h3C,
  parameter logic [15:0] CIRC_WORD = 16'h55AA
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [7:0]       exp_id,
  input  logic [15:0]      rx_data,
  input  logic             rx_valid,
  input  logic             rx_err,
  output logic             locked,
  output logic             err_flag,
  output logic             id_mismatch,
  output logic [CNT_W-1:0] err_count,
  output logic [CNT_W-1:0] word_count
);

  lpc_mode_e   mode_e;
  logic        lock_evt;
  logic [15:0] expected;
  logic        prev_valid_q;
  logic        cmp;
  logic        word_bad;
  logic        toggle_bad;
  logic        err_inc;
  logic        id_bad;

  assign mode_e = lpc_mode_e'(mode);

  lpc_sync_hunt #(
    .WORD_W   (WORD_W),
    .SYNC_LEN (SYNC_LEN),
    .SYNC_WORD(SYNC_WORD)
  ) u_hunt (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .rx_data (rx_data),
    .rx_valid(rx_valid),
    .lock_evt(lock_evt),
    .locked  (locked)
  );

  assign cmp        = locked && !start && rx_valid;
  assign word_bad   = cmp && (rx_err || (rx_data != expected));
  assign toggle_bad = locked && !start && (mode_e == MODE_CIRC) && (rx_valid == prev_valid_q);
  assign err_inc    = word_bad || toggle_bad;
  assign id_bad     = cmp && !rx_err && (mode_e == MODE_STATIC) && (rx_data[15:8] != exp_id);

  lpc_ref_gen #(
    .SEED     (SEED),
    .STATIC_LO(STATIC_LO),
    .CIRC_WORD(CIRC_WORD)
  ) u_ref (
    .clk     (clk),
    .rst     (rst),
    .load    (lock_evt),
    .adv     (cmp),
    .mode    (mode_e),
    .exp_id  (exp_id),
    .expected(expected)
  );

  lpc_sat_counter #(.CNT_W(CNT_W)) u_err_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (start),
    .inc  (err_inc),
    .count(err_count)
  );

  lpc_sat_counter #(.CNT_W(CNT_W)) u_word_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (start),
    .inc  (cmp),
    .count(word_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_valid_q <= 1'b0;
      err_flag     <= 1'b0;
      id_mismatch  <= 1'b0;
    end else begin
      prev_valid_q <= rx_valid;
      if (start) begin
        err_flag    <= 1'b0;
        id_mismatch <= 1'b0;
      end else begin
        if (err_inc) err_flag    <= 1'b1;
        if (id_bad)  id_mismatch <= 1'b1;
      end
    end
  end

  AST_QUIET_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    (!locked && !start) |=> ($stable(err_count) && $stable(word_count))) else $error("count before lock");  // R3

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !start) |=> err_flag) else $error("err_flag dropped");  // R5

  AST_ID_STICKY: assert property (@(posedge clk) disable iff (rst)
    (id_mismatch && !start) |=> id_mismatch) else $error("id_mismatch dropped");  // R8

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start |=> (err_count == '0 && word_count == '0 && !locked)) else $error("start did not clear");  // R1

endmodule

// File: tb/link_pattern_checker_tb.sv
module link_pattern_checker_tb;

  localparam int          CW        = 8;
  localparam logic [15:0] SYNC      = 16'hBC50;
  localparam logic [15:0] SEED      = 16'hACE1;
  localparam logic [15:0] CIRC      = 16'h55AA;
  localparam logic [7:0]  SLO       = 8'h3C;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    mode = 2'd2;
  logic [7:0]    exp_id = 8'h00;
  logic [15:0]   rx_data = '0;
  logic          rx_valid = 1'b0;
  logic          rx_err = 1'b0;
  logic          locked, err_flag, id_mismatch;
  logic [CW-1:0] err_count, word_count;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  link_pattern_checker #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .exp_id(exp_id),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_err(rx_err),
    .locked(locked), .err_flag(err_flag), .id_mismatch(id_mismatch),
    .err_count(err_count), .word_count(word_count)
  );

  function automatic logic [15:0] ref_lfsr(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one cycle from a negedge, return at the next negedge
  task automatic cyc(input logic v, input logic [15:0] d, input logic e);
    rx_valid = v; rx_data = d; rx_err = e;
    @(negedge clk);
    rx_valid = 1'b0; rx_err = 1'b0;
  endtask

  task automatic do_start();
    start = 1'b1;
    cyc(1'b0, 16'h0, 1'b0);
    start = 1'b0;
  endtask

  task automatic do_sync();
    cyc(1'b1, SYNC, 1'b0);
    cyc(1'b1, SYNC, 1'b0);
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] s;
    logic [15:0] d;
    int nvalid;
    void'($urandom(32'd20241027));
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset err_count", int'(err_count), 0);
    chk("R1 reset word_count", int'(word_count), 0);
    chk("R1 reset flags", int'({locked, err_flag, id_mismatch}), 0);

    // R3 random traffic before lock is ignored
    mode = 2'd2;
    for (int i = 0; i < 12; i++) begin
      d = 16'($urandom);
      if (d == SYNC) d = d ^ 16'h1;
      cyc(1'b1, d, 1'($urandom % 2));
    end
    chk("R3 no errors before lock", int'(err_count), 0);
    chk("R3 no words before lock", int'(word_count), 0);
    chk("R3 no flag before lock", int'(err_flag), 0);

    // R2 broken run, then run with an idle gap
    cyc(1'b1, SYNC, 1'b0);
    cyc(1'b1, 16'h1234, 1'b0);
    cyc(1'b1, SYNC, 1'b0);
    chk("R2 broken sync run not locked", int'(locked), 0);
    cyc(1'b0, SYNC, 1'b0);
    cyc(1'b1, SYNC, 1'b0);
    chk("R2 locked after sync with idle gap", int'(locked), 1);

    // R4 R5 R6 ramp with random idles and one corrupted word
    for (int i = 0; i < 40; i++) begin
      if ($urandom % 4 == 0) cyc(1'b0, 16'hFFFF, 1'b0);
      cyc(1'b1, (i == 17) ? 16'(i) ^ 16'h0040 : 16'(i), 1'b0);
    end
    chk("R4 word count ignores idles", int'(word_count), 40);
    chk("R6 R5 one error for one bad ramp word", int'(err_count), 1);
    chk("R5 err_flag set", int'(err_flag), 1);
    cyc(1'b1, 16'd40, 1'b1);
    chk("R5 rx_err word counted as error", int'(err_count), 2);
    chk("R2 still locked", int'(locked), 1);

    // R1 start clears
    do_start();
    chk("R1 start clears counters", int'(err_count) + int'(word_count), 0);
    chk("R1 start clears lock and flags", int'({locked, err_flag, id_mismatch}), 0);

    // R7 pseudo-random
    mode = 2'd3;
    do_sync();
    s = SEED;
    for (int i = 0; i < 50; i++) begin
      cyc(1'b1, (i == 23) ? s ^ 16'h0100 : s, 1'b0);
      s = ref_lfsr(s);
    end
    chk("R7 prbs words", int'(word_count), 50);
    chk("R7 one corrupt prbs word gives one error", int'(err_count), 1);

    // R8 static
    do_start();
    mode = 2'd0; exp_id = 8'h5E;
    do_sync();
    for (int i = 0; i < 5; i++) cyc(1'b1, {8'h5E, SLO}, 1'b0);
    chk("R8 static correct no error", int'(err_count), 0);
    chk("R8 static correct no id mismatch", int'(id_mismatch), 0);
    cyc(1'b1, {8'h5F, SLO}, 1'b0);
    chk("R8 wrong id counted", int'(err_count), 1);
    chk("R8 id_mismatch set", int'(id_mismatch), 1);
    cyc(1'b1, {8'h5E, SLO}, 1'b0);
    chk("R8 id_mismatch sticky", int'(id_mismatch), 1);

    // R9 circular
    do_start();
    mode = 2'd1;
    do_sync();
    cyc(1'b0, 16'h0, 1'b0); cyc(1'b1, CIRC, 1'b0);
    cyc(1'b0, 16'h0, 1'b0); cyc(1'b1, CIRC, 1'b0);
    chk("R9 circular toggling clean", int'(err_count), 0);
    chk("R9 circular words", int'(word_count), 2);
    cyc(1'b0, 16'h0, 1'b0); cyc(1'b0, 16'h0, 1'b0);
    chk("R9 repeated idle level is an error", int'(err_count), 1);
    cyc(1'b1, CIRC, 1'b0); cyc(1'b1, CIRC, 1'b0);
    chk("R9 repeated valid level is an error", int'(err_count), 2);
    cyc(1'b0, 16'h0, 1'b0); cyc(1'b1, CIRC ^ 16'h0001, 1'b0);
    chk("R9 wrong circular data", int'(err_count), 3);
    chk("R9 circular word total", int'(word_count), 5);

    // R10 saturation
    do_start();
    mode = 2'd2;
    do_sync();
    nvalid = 0;
    for (int i = 0; i < 300; i++) begin
      cyc(1'b1, 16'(i), 1'b0);
      nvalid++;
    end
    chk("R10 word counter saturates", int'(word_count), (nvalid > 255) ? 255 : nvalid);
    chk("R10 clean ramp no errors", int'(err_count), 0);
    for (int i = 300; i < 600; i++) cyc(1'b1, 16'(i) ^ 16'h8000, 1'b0);
    chk("R10 error counter saturates", int'(err_count), 255);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule